// File: doc/BRIEF.md
# Microprogram Sequencer with Condition Match

This block steps through microcode for a microcoded datapath. It holds a microprogram counter that points into a microcode store. The store is a register array whose contents come from a parameter table. In each cycle the block reads the microword at the current microaddress and presents that word's datapath control field. It then picks the next microaddress. That is either the current address plus one, or the word's target field when a jump is taken.

A word can end the current routine. The block then raises a fetch request for one cycle. During the following cycle the control field is held at zero while the datapath supplies an 8-bit machine opcode. At the end of that cycle the opcode, zero-extended, becomes the new microaddress. A routine therefore starts at the address equal to its opcode.

The jump decision is a bitwise AND between the live status flags and a mask in the microword, followed by an OR reduction. A jump-enable bit gates the decision. An all-zero mask with jump-enable set jumps unconditionally.

Top module: `useq_core`

## Requirements
- R1: While reset is low the microaddress is 0. After reset is released, the first word executed is the one at address 0.
- R2: A word whose end bit is set drives fetch_req_o high in its cycle. The next cycle is a fetch cycle: the microaddress is held, ctrl_o is 0 and fetch_req_o is 0.
- R3: At the end of a fetch cycle the microaddress becomes opcode_i, zero-extended to the address width.
- R4: A word with jump-enable clear and end bit clear advances the microaddress by one. Addresses past the parameter table are included.
- R5: A word with jump-enable set and an all-zero mask always loads its target field as the next microaddress.
- R6: A word with jump-enable set and a non-zero mask jumps to its target field only if some flag whose mask bit is 1 is set. Otherwise it advances by one. Bits 3 to 0 of both flags_i and the mask are n, c, v, z.
- R7: A word with jump-enable clear never jumps, whatever its mask and the flags.
- R8: Outside fetch cycles, ctrl_o is the control field of the word at the current microaddress. Addresses not covered by the table read as all-zero words. The word layout, from MSB to LSB, is: end bit, jump-enable, 4-bit mask, target address, control field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 8 | Machine opcode, sampled in the fetch cycle |
| flags_i | input | 4 | ALU status {n,c,v,z} |
| ctrl_o | output | 24 | Datapath control field |
| fetch_req_o | output | 1 | Current word ends the routine |
| upc_o | output | 10 | Current microaddress |

## Verification
ctrl_o and fetch_req_o follow combinationally from the current microaddress. They are due in the same cycle the address is reached. The flags and the opcode act only at the next rising edge, and their effect shows in upc_o one cycle later. The bench therefore drives each vector's inputs on the falling edge and compares the outputs shortly after. The result of the flags or opcode from one vector is checked in the following vector. The asynchronous reset is checked immediately, without waiting for an edge.

// File: rtl/useq_core.sv
module useq_core #(
  parameter int OPC_W  = 8,
  parameter int ADDR_W = 10,
  parameter int CTRL_W = 24,
  parameter int TBL_N  = 4,
  parameter logic [TBL_N*(CTRL_W+ADDR_W+6)-1:0] UCODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic [3:0]        flags_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] upc_o
);
  localparam int WORD_W = CTRL_W + ADDR_W + 6;
  localparam int IDX_W  = (TBL_N > 1) ? $clog2(TBL_N) : 1;

  logic [WORD_W-1:0] store [TBL_N];
  logic [WORD_W-1:0] word;
  logic [ADDR_W-1:0] upc_q, nxt;
  logic [3:0]        mask;
  logic              pend_q, eor, jen, take;

  for (genvar i = 0; i < TBL_N; i++) begin : g_store
    assign store[i] = UCODE[i*WORD_W +: WORD_W];
  end

  assign word = (int'(upc_q) < TBL_N) ? store[upc_q[IDX_W-1:0]] : '0;
  assign eor  = word[WORD_W-1];
  assign jen  = word[WORD_W-2];
  assign mask = word[WORD_W-3 -: 4];
  assign nxt  = word[CTRL_W +: ADDR_W];
  assign take = jen & ((mask == 4'b0) | (|(flags_i & mask)));

  assign ctrl_o      = pend_q ? '0 : word[CTRL_W-1:0];
  assign fetch_req_o = eor & ~pend_q;
  assign upc_o       = upc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc_q  <= '0;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      upc_q  <= {{(ADDR_W-OPC_W){1'b0}}, opcode_i};
      pend_q <= 1'b0;
    end else if (eor) begin
      pend_q <= 1'b1;
    end else if (take) begin
      upc_q  <= nxt;
    end else begin
      upc_q  <= upc_q + 1'b1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> upc_o == '0);
  p_fetch_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |=> (ctrl_o == '0) && !fetch_req_o && $stable(upc_o));
  p_load_opcode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q) |=> upc_o == ADDR_W'($past(opcode_i)));
  p_increment_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !eor && !take) |=> upc_o == $past(upc_o) + 1'b1);
  p_jump_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !eor && take) |=> upc_o == $past(nxt));
endmodule

// File: tb/sim_useq_core.sv
module sim_useq_core;
  localparam int PERIOD = 10;
  localparam int N = 32;
  localparam int WW = 40;
  localparam int NV = 27;

  function automatic logic [23:0] ct(input int a);
    return 24'h5A0000 | 24'(a);
  endfunction

  function automatic logic [WW-1:0] mw(input logic e, input logic j,
      input logic [3:0] m, input int t, input logic [23:0] c);
    return {e, j, m, 10'(t), c};
  endfunction

  function automatic logic [N*WW-1:0] build();
    logic [N*WW-1:0] p = '0;
    p[0*WW +: WW]  = mw(1, 0, 4'h0, 0, 24'h0F0F0F);
    p[2*WW +: WW]  = mw(1, 0, 4'h0, 0, ct(2));
    p[5*WW +: WW]  = mw(0, 0, 4'h0, 0, ct(5));
    p[6*WW +: WW]  = mw(0, 1, 4'h0, 10, ct(6));
    p[10*WW +: WW] = mw(0, 1, 4'h1, 20, ct(10));
    p[11*WW +: WW] = mw(1, 0, 4'h0, 0, ct(11));
    p[12*WW +: WW] = mw(0, 0, 4'h6, 25, ct(12));
    p[13*WW +: WW] = mw(1, 0, 4'h0, 0, ct(13));
    p[20*WW +: WW] = mw(0, 1, 4'h8, 2, ct(20));
    p[21*WW +: WW] = mw(1, 0, 4'h0, 0, ct(21));
    return p;
  endfunction

  localparam logic [N*WW-1:0] PROG = build();

  // {opcode, flags, upc, ctrl, fetch}
  localparam logic [46:0] VEC [NV] = '{
    {8'd0,  4'h0, 10'd0,  24'h0F0F0F, 1'b1},
    {8'd5,  4'h0, 10'd0,  24'h0,      1'b0},
    {8'd0,  4'h0, 10'd5,  24'h5A0005, 1'b0},
    {8'd0,  4'h0, 10'd6,  24'h5A0006, 1'b0},
    {8'd0,  4'h1, 10'd10, 24'h5A000A, 1'b0},
    {8'd0,  4'h7, 10'd20, 24'h5A0014, 1'b0},
    {8'd0,  4'h0, 10'd21, 24'h5A0015, 1'b1},
    {8'd5,  4'h0, 10'd21, 24'h0,      1'b0},
    {8'd0,  4'h0, 10'd5,  24'h5A0005, 1'b0},
    {8'd0,  4'h0, 10'd6,  24'h5A0006, 1'b0},
    {8'd0,  4'hE, 10'd10, 24'h5A000A, 1'b0},
    {8'd0,  4'h0, 10'd11, 24'h5A000B, 1'b1},
    {8'd12, 4'h0, 10'd11, 24'h0,      1'b0},
    {8'd0,  4'hF, 10'd12, 24'h5A000C, 1'b0},
    {8'd0,  4'h0, 10'd13, 24'h5A000D, 1'b1},
    {8'd5,  4'h0, 10'd13, 24'h0,      1'b0},
    {8'd0,  4'h0, 10'd5,  24'h5A0005, 1'b0},
    {8'd0,  4'h0, 10'd6,  24'h5A0006, 1'b0},
    {8'd0,  4'h1, 10'd10, 24'h5A000A, 1'b0},
    {8'd0,  4'h8, 10'd20, 24'h5A0014, 1'b0},
    {8'd0,  4'h0, 10'd2,  24'h5A0002, 1'b1},
    {8'd0,  4'h0, 10'd2,  24'h0,      1'b0},
    {8'd0,  4'h0, 10'd0,  24'h0F0F0F, 1'b1},
    {8'd30, 4'h0, 10'd0,  24'h0,      1'b0},
    {8'd0,  4'h0, 10'd30, 24'h0,      1'b0},
    {8'd0,  4'h0, 10'd31, 24'h0,      1'b0},
    {8'd0,  4'h0, 10'd32, 24'h0,      1'b0}
  };

  function automatic string tag(input int i);
    case (i)
      0, 22: return "R1";
      1, 7, 12, 15, 21, 23: return "R2";
      2, 8, 16, 24: return "R3";
      3, 9, 17: return "R4";
      4, 10, 18: return "R5";
      5, 19, 20: return "R6";
      11: return "R6 no-match";
      13, 14: return "R7";
      default: return "R8";
    endcase
  endfunction

  logic clk = 0, rst_n = 0;
  logic [7:0] opcode = '0;
  logic [3:0] flags = '0;
  logic [23:0] ctrl;
  logic fetch;
  logic [9:0] upc;
  int runs = 0, fails = 0;

  useq_core #(.TBL_N(N), .UCODE(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode), .flags_i(flags),
    .ctrl_o(ctrl), .fetch_req_o(fetch), .upc_o(upc));

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string t, input logic [9:0] eu,
      input logic [23:0] ec, input logic ef);
    runs++;
    if (upc !== eu || ctrl !== ec || fetch !== ef) begin
      fails++;
      $display("FAIL %s: upc=%0d ctrl=%h fetch=%b, expected upc=%0d ctrl=%h fetch=%b",
               t, upc, ctrl, fetch, eu, ec, ef);
    end
  endtask

  initial begin
    #(PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: run incomplete, expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    #1 check("R1 in reset", 10'd0, 24'h0F0F0F, 1'b1);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      opcode = VEC[i][46:39];
      flags  = VEC[i][38:35];
      #1 check(tag(i), VEC[i][34:25], VEC[i][24:1], VEC[i][0]);
      @(negedge clk);
    end
    check("R4 past table", 10'd33, 24'h0, 1'b0);
    rst_n = 0;
    #1 check("R1 async reset", 10'd0, 24'h0F0F0F, 1'b1);
    @(negedge clk) rst_n = 1;
    opcode = 8'd12;
    @(negedge clk);
    #1 check("R2 fetch after reset", 10'd0, 24'h0, 1'b0);
    @(negedge clk) flags = 4'h6;
    #1 check("R7 jump disabled", 10'd12, ct(12), 1'b0);
    @(negedge clk);
    #1 check("R7 advanced", 10'd13, ct(13), 1'b1);
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule